// File: doc/BRIEF.md
# Time-Stamp Counter with Typed Event Queue

This block keeps a free-running 32-bit time counter and logs time-stamped events into a small queue. Events come from a software push write, from hardware input pins, from counter wrap (both the full wrap and the crossing into the upper half), and from Ethernet receive and transmit requests. The Ethernet requests carry a PTP message type, a sequence ID and a port number. Each queued entry records the counter value, a 4-bit kind code and that metadata. A level interrupt stays high while the queue holds entries. Host software can therefore time packets and pin edges, and can count wraps to extend time beyond 32 bits.

The host reaches the block through a synchronous register port. A write takes effect at the clock edge where `reg_we` is high. Reads are combinational from `reg_addr` and have no side effects. Each Ethernet source uses a valid/ready handshake. A request is taken at an edge where both signals are high. `ready` stays low while the source's previous request is still waiting for a queue slot, and while the unit is disabled. The requester must hold `valid` and its metadata until it sees `ready`. The hardware pins are plain asynchronous inputs.

Register addresses: 0 control, 1 push, 2 load value, 3 load strobe, 4 raw status, 5 masked status, 6 interrupt enable, 7 pop, 8 event low word, 9 event high word. Unmapped addresses read as zero.

Top module: `tsq_unit`

## Requirements
- R1: Control bit 0 (address 0) enables the unit. While the unit is enabled the counter advances by one each cycle. While it is disabled the counter holds its value, no event is accepted, the queue is emptied, any waiting requests are discarded and the overflow flag is cleared.
- R2: A write of bit 0 = 1 to address 3 copies the value held at address 2 into the counter at that edge. A load works whether or not the unit is enabled.
- R3: A write of bit 0 = 1 to address 1 queues a software event. Its stamp is the counter value present in the cycle of the write, so back-to-back push writes give consecutive stamps.
- R4: Address 8 returns the head entry's stamp. Address 9 returns port in bits 28:24, kind in bits 23:20, message type in bits 19:16 and sequence ID in bits 15:0. Kind codes are: 0 software, 1 full wrap, 2 half wrap, 3 pin, 4 receive, 5 transmit.
- R5: When the counter increments from all-ones to zero, a kind-1 event with stamp 0 is queued. When it increments from 0x7FFFFFFF to 0x80000000, a kind-2 event with stamp 0x80000000 is queued.
- R6: Each hardware pin passes through a two-flop synchronizer. A rising edge queues one kind-3 event only when that pin's enable bit is set, with pin i enabled by control bit 8+i. The port field is i+1. A pin held high does not queue a second event.
- R7: For each Ethernet source, ready is high only when the unit is enabled and that source has no request waiting. An accepted request becomes a kind-4 (receive) or kind-5 (transmit) event carrying its message type, sequence ID and port. Ready falls in the cycle after an acceptance.
- R8: The queue takes at most one event per cycle. Waiting requests are served in this order: wrap events, software push, pins in ascending index, receive, then transmit. Requests accepted at the same edge keep the stamp of that edge.
- R9: The queue holds 16 entries. An event that finds the queue full is dropped and sets a sticky overflow flag, read at bit 1 of address 4.
- R10: A write of bit 0 = 1 to address 7 removes the head entry. A pop on an empty queue has no effect. Both event words read zero while the queue is empty.
- R11: Raw status bit 0 (address 4) is high while the queue is non-empty or control bit 1 (test) is set. Masked status bit 0 (address 5) and the `irq` pin equal that bit ANDed with bit 0 of address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register address |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| hw_pin | input | 4 | Asynchronous hardware capture pins |
| rx_valid | input | 1 | Receive time-stamp request valid |
| rx_ready | output | 1 | Receive request accepted when high with valid |
| rx_msg | input | 4 | Receive PTP message type |
| rx_seq | input | 16 | Receive PTP sequence ID |
| rx_port | input | 5 | Receive port number |
| tx_valid | input | 1 | Transmit time-stamp request valid |
| tx_ready | output | 1 | Transmit request accepted when high with valid |
| tx_msg | input | 4 | Transmit PTP message type |
| tx_seq | input | 16 | Transmit PTP sequence ID |
| tx_port | input | 5 | Transmit port number |
| irq | output | 1 | Level interrupt |

## Verification
The bench loads the counter just below each wrap point and checks that exactly one wrap entry appears, with stamp 0 or 0x80000000. A design that tested the wrong bit, or stamped the old counter value, would show a missing entry, a duplicate entry or a wrong stamp. It fires a push, a receive and a transmit request at the same edge and checks the queue order and that all three stamps are equal. A flawed arbiter would reorder the entries, lose one, or stamp each at its service cycle. It pushes seventeen events in a row to check that the sixteen oldest survive with consecutive stamps, that the overflow flag sticks, and that a pop on an empty queue changes nothing. Off-by-one full logic, or a pop that underflows, would corrupt that sequence. Other scenarios check that a disabled pin is ignored, that disabling the unit freezes the counter and flushes the queue, and that the test bit drives the interrupt.

// File: rtl/tsq_pkg.sv
package tsq_pkg;
  localparam int RA_W = 4;

  localparam logic [RA_W-1:0] A_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] A_PUSH  = 4'd1;
  localparam logic [RA_W-1:0] A_LDVAL = 4'd2;
  localparam logic [RA_W-1:0] A_LDGO  = 4'd3;
  localparam logic [RA_W-1:0] A_RAW   = 4'd4;
  localparam logic [RA_W-1:0] A_MASK  = 4'd5;
  localparam logic [RA_W-1:0] A_IEN   = 4'd6;
  localparam logic [RA_W-1:0] A_POP   = 4'd7;
  localparam logic [RA_W-1:0] A_EVLO  = 4'd8;
  localparam logic [RA_W-1:0] A_EVHI  = 4'd9;

  typedef enum logic [3:0] {
    EV_PUSH = 4'd0, EV_ROLL = 4'd1, EV_HALF = 4'd2,
    EV_PIN  = 4'd3, EV_RX   = 4'd4, EV_TX   = 4'd5
  } ev_kind_e;

  typedef struct packed {
    logic [31:0] stamp;
    logic [4:0]  port;
    logic [3:0]  kind;
    logic [3:0]  msg;
    logic [15:0] seq;
  } ev_rec_t;
endpackage

// File: rtl/tsq_pin_sync.sv
module tsq_pin_sync #(
  parameter int NPINS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin,
  output logic [NPINS-1:0] rise
);
  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [2:0] sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh <= '0;
      else        sh <= {sh[1:0], pin[g]};
    end
    assign rise[g] = sh[1] & ~sh[2];
  end
endmodule

// File: rtl/tsq_pick.sv
module tsq_pick #(
  parameter int N = 8
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic found;
    found = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt[i] = 1'b1;
        found  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsq_fifo.sv
module tsq_fifo import tsq_pkg::*; #(
  parameter  int DEPTH = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          wr_en,
  input  ev_rec_t       wr_rec,
  input  logic          rd_en,
  output ev_rec_t       head,
  output logic          empty,
  output logic          dropped,
  output logic [CW-1:0] count
);
  ev_rec_t       mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_wr, do_rd;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_wr   = wr_en & ~full;
  assign do_rd   = rd_en & ~empty;
  assign dropped = wr_en & full;
  assign head    = empty ? '0 : mem[rp];

  always_ff @(posedge clk) begin
    if (do_wr && !flush) mem[wp] <= wr_rec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0;
    end else if (flush) begin
      wp <= '0; rp <= '0; count <= '0;
    end else begin
      if (do_wr) wp <= nxt(wp);
      if (do_rd) rp <= nxt(rp);
      if (do_wr && !do_rd)      count <= count + 1'b1;
      else if (do_rd && !do_wr) count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/tsq_unit.sv
module tsq_unit import tsq_pkg::*; #(
  parameter  int DEPTH = 16,
  parameter  int NPINS = 4,
  localparam int NSRC  = NPINS + 4,
  localparam int S_ROLL = 0,
  localparam int S_PUSH = 1,
  localparam int S_PIN0 = 2,
  localparam int S_RX   = NPINS + 2,
  localparam int S_TX   = NPINS + 3,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [RA_W-1:0]  reg_addr,
  input  logic             reg_we,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic [NPINS-1:0] hw_pin,
  input  logic             rx_valid,
  output logic             rx_ready,
  input  logic [3:0]       rx_msg,
  input  logic [15:0]      rx_seq,
  input  logic [4:0]       rx_port,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [3:0]       tx_msg,
  input  logic [15:0]      tx_seq,
  input  logic [4:0]       tx_port,
  output logic             irq
);
  localparam logic [31:0] CTRL_MASK = ((32'h1 << NPINS) - 32'h1) << 8 | 32'h3;

  logic [31:0] ctrl_q, ldval_q, cnt_q;
  logic        ien_q, ov_q;
  logic        en_q, test_q, load, pop, pend_bit;
  logic [NPINS-1:0] pin_en, pin_rise;

  logic [NSRC-1:0] src_req, pend_q, gnt;
  ev_rec_t         src_rec [NSRC];
  ev_rec_t         slot_q  [NSRC];
  ev_rec_t         enq_rec, head;
  logic            enq, q_empty, q_drop;
  logic [CW-1:0]   q_count;

  assign en_q   = ctrl_q[0];
  assign test_q = ctrl_q[1];
  assign pin_en = ctrl_q[8 +: NPINS];
  assign load   = reg_we && reg_addr == A_LDGO && reg_wdata[0];
  assign pop    = reg_we && reg_addr == A_POP  && reg_wdata[0];

  // Host-writable registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; ldval_q <= '0; ien_q <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL:  ctrl_q  <= reg_wdata & CTRL_MASK;
        A_LDVAL: ldval_q <= reg_wdata;
        A_IEN:   ien_q   <= reg_wdata[0];
        default: ;
      endcase
    end
  end

  // Time counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (load) cnt_q <= ldval_q;
    else if (en_q) cnt_q <= cnt_q + 32'd1;
  end

  tsq_pin_sync #(.NPINS(NPINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(hw_pin), .rise(pin_rise)
  );

  assign rx_ready = en_q & ~pend_q[S_RX];
  assign tx_ready = en_q & ~pend_q[S_TX];

  // Event sources
  always_comb begin
    logic roll, half;
    roll = en_q && !load && (cnt_q == 32'hFFFF_FFFF);
    half = en_q && !load && (cnt_q == 32'h7FFF_FFFF);
    src_req[S_ROLL] = roll | half;
    src_rec[S_ROLL] = '{stamp: cnt_q + 32'd1, port: '0,
                        kind: roll ? 4'(EV_ROLL) : 4'(EV_HALF), msg: '0, seq: '0};
    src_req[S_PUSH] = reg_we && reg_addr == A_PUSH && reg_wdata[0];
    src_rec[S_PUSH] = '{stamp: cnt_q, port: '0, kind: 4'(EV_PUSH), msg: '0, seq: '0};
    for (int i = 0; i < NPINS; i++) begin
      src_req[S_PIN0+i] = pin_rise[i] & pin_en[i];
      src_rec[S_PIN0+i] = '{stamp: cnt_q, port: 5'(i + 1), kind: 4'(EV_PIN),
                            msg: '0, seq: '0};
    end
    src_req[S_RX] = rx_valid & rx_ready;
    src_rec[S_RX] = '{stamp: cnt_q, port: rx_port, kind: 4'(EV_RX),
                      msg: rx_msg, seq: rx_seq};
    src_req[S_TX] = tx_valid & tx_ready;
    src_rec[S_TX] = '{stamp: cnt_q, port: tx_port, kind: 4'(EV_TX),
                      msg: tx_msg, seq: tx_seq};
  end

  // Per-source waiting slots
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend_q <= '0;
    else if (!en_q) pend_q <= '0;
    else begin
      for (int i = 0; i < NSRC; i++) begin
        if (!(pend_q[i] && !gnt[i])) pend_q[i] <= src_req[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSRC; i++) begin
      if (!(pend_q[i] && !gnt[i]) && src_req[i]) slot_q[i] <= src_rec[i];
    end
  end

  tsq_pick #(.N(NSRC)) u_pick (.req(pend_q), .gnt(gnt));

  always_comb begin
    enq_rec = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (gnt[i]) enq_rec = slot_q[i];
    end
  end
  assign enq = en_q & (|gnt);

  tsq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(~en_q), .wr_en(enq), .wr_rec(enq_rec),
    .rd_en(pop), .head(head), .empty(q_empty), .dropped(q_drop), .count(q_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ov_q <= 1'b0;
    else if (!en_q) ov_q <= 1'b0;
    else if (q_drop) ov_q <= 1'b1;
  end

  assign pend_bit = ~q_empty | test_q;
  assign irq      = pend_bit & ien_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_q;
      A_LDVAL: reg_rdata = ldval_q;
      A_RAW:   reg_rdata = {30'd0, ov_q, pend_bit};
      A_MASK:  reg_rdata = {31'd0, irq};
      A_IEN:   reg_rdata = {31'd0, ien_q};
      A_EVLO:  reg_rdata = head.stamp;
      A_EVHI:  reg_rdata = {3'd0, head.port, head.kind, head.msg, head.seq};
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter  int DEPTH = 16,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en_q,
  input logic          test_q,
  input logic          load,
  input logic [31:0]   cnt_q,
  input logic [CW-1:0] count,
  input logic          ov_q,
  input logic          rx_valid,
  input logic          rx_ready,
  input logic          pop,
  input logic          empty,
  input logic          enq,
  input logic          irq
);
  a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r1_flush: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> count == '0);

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !load) |=> $stable(cnt_q));

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !load) |=> cnt_q == $past(cnt_q) + 32'd1);

  a_r9_sticky_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && en_q) |=> ov_q);

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !rx_ready);

  a_r10_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !enq) |=> empty);

  a_r11_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (!empty || test_q));
endmodule

bind tsq_unit tsq_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_q(en_q), .test_q(test_q), .load(load),
  .cnt_q(cnt_q), .count(q_count), .ov_q(ov_q), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .pop(pop), .empty(q_empty), .enq(enq), .irq(irq)
);

// File: tb/tb_tsq_unit.sv
module tb_tsq_unit;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic [3:0]  hw_pin = '0;
  logic        rx_valid = 0, rx_ready, tx_valid = 0, tx_ready, irq;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic [4:0]  rx_port = '0, tx_port = '0;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  tsq_unit dut (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; #1;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd0, v); check("R1 ctrl after reset", v, 32'h0);
    rd(4'd4, v); check("R11 raw after reset", v, 32'h0);
    check("R11 irq after reset", {31'd0, irq}, 32'h0);
    check("R7 rx_ready while disabled", {31'd0, rx_ready}, 32'h0);
  endtask

  task automatic t_load_push;
    logic [31:0] v;
    wr(4'd0, 32'h1);
    wr(4'd2, 32'h0000_1000);
    wr(4'd3, 32'h1);
    wr(4'd1, 32'h1);
    wr(4'd1, 32'h1);
    idle(3);
    rd(4'd8, v); check("R2 stamp after load", v, 32'h0000_1000);
    rd(4'd9, v); check("R4 push high word", v, 32'h0);
    wr(4'd7, 32'h1);
    rd(4'd8, v); check("R3 next push stamp", v, 32'h0000_1001);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R10 empty after pops", v, 32'h0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(4'd1, 32'h1);
    wr(4'd2, 32'h0000_0500);
    wr(4'd3, 32'h1);
    wr(4'd0, 32'h0);
    idle(5);
    rd(4'd4, v); check("R1 flushed on disable", v, 32'h0);
    wr(4'd0, 32'h1);
    wr(4'd1, 32'h1);
    idle(3);
    rd(4'd8, v); check("R1 counter held while disabled", v, 32'h0000_0501);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R1 only new event remains", v, 32'h0);
  endtask

  task automatic t_roll;
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FFFE);
    wr(4'd3, 32'h1);
    idle(5);
    rd(4'd8, v); check("R5 wrap stamp", v, 32'h0);
    rd(4'd9, v); check("R5 wrap kind", v, 32'h0010_0000);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R5 single wrap event", v, 32'h0);
    wr(4'd2, 32'h7FFF_FFFE);
    wr(4'd3, 32'h1);
    idle(5);
    rd(4'd8, v); check("R5 half stamp", v, 32'h8000_0000);
    rd(4'd9, v); check("R5 half kind", v, 32'h0020_0000);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R5 single half event", v, 32'h0);
  endtask

  task automatic t_prio;
    logic [31:0] v, s;
    rx_msg = 4'd3; rx_seq = 16'hABCD; rx_port = 5'd2;
    tx_msg = 4'd1; tx_seq = 16'h1234; tx_port = 5'd1;
    @(negedge clk);
    check("R7 rx_ready idle", {31'd0, rx_ready}, 32'h1);
    reg_addr = 4'd1; reg_wdata = 32'h1; reg_we = 1;
    rx_valid = 1; tx_valid = 1;
    @(posedge clk); #1;
    reg_we = 0; rx_valid = 0; tx_valid = 0;
    check("R7 rx_ready low after accept", {31'd0, rx_ready}, 32'h0);
    idle(5);
    rd(4'd9, v); check("R8 first is push", v, 32'h0);
    rd(4'd8, s);
    wr(4'd7, 32'h1);
    rd(4'd9, v); check("R8 R4 second is rx", v, 32'h0243_ABCD);
    rd(4'd8, v); check("R8 rx same stamp", v, s);
    wr(4'd7, 32'h1);
    rd(4'd9, v); check("R8 R4 third is tx", v, 32'h0151_1234);
    rd(4'd8, v); check("R8 tx same stamp", v, s);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R8 queue drained", v, 32'h0);
  endtask

  task automatic t_pins;
    logic [31:0] v;
    wr(4'd0, 32'h0000_0201);
    @(negedge clk); hw_pin = 4'b0011;
    idle(8);
    rd(4'd9, v); check("R6 pin event fields", v, 32'h0230_0000);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R6 disabled pin ignored, no retrigger", v, 32'h0);
    @(negedge clk); hw_pin = 4'b0000;
    wr(4'd0, 32'h1);
  endtask

  task automatic t_ovf;
    logic [31:0] v, s;
    for (int i = 0; i < 17; i++) wr(4'd1, 32'h1);
    idle(4);
    rd(4'd4, v); check("R9 overflow and pending", v, 32'h3);
    rd(4'd8, s);
    for (int i = 0; i < 16; i++) begin
      rd(4'd8, v); check("R9 kept stamps in order", v, s + 32'(i));
      wr(4'd7, 32'h1);
    end
    rd(4'd4, v); check("R9 seventeenth dropped", v, 32'h2);
    rd(4'd8, v); check("R10 empty low word", v, 32'h0);
    rd(4'd9, v); check("R10 empty high word", v, 32'h0);
    wr(4'd7, 32'h1);
    wr(4'd1, 32'h1);
    idle(3);
    wr(4'd7, 32'h1);
    rd(4'd4, v); check("R10 empty pop had no effect", v, 32'h2);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    wr(4'd1, 32'h1);
    idle(3);
    rd(4'd5, v); check("R11 masked off", v, 32'h0);
    check("R11 irq masked", {31'd0, irq}, 32'h0);
    wr(4'd6, 32'h1);
    rd(4'd5, v); check("R11 masked on", v, 32'h1);
    check("R11 irq on", {31'd0, irq}, 32'h1);
    wr(4'd7, 32'h1);
    #1 check("R11 irq off when empty", {31'd0, irq}, 32'h0);
    wr(4'd0, 32'h3);
    rd(4'd4, v); check("R11 test bit raw", v & 32'h1, 32'h1);
    check("R11 test bit irq", {31'd0, irq}, 32'h1);
    wr(4'd0, 32'h1);
    #1 check("R11 test cleared", {31'd0, irq}, 32'h0);
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(3);
    @(negedge clk) rst_n = 1;
    t_reset;
    t_load_push;
    t_hold;
    t_roll;
    t_prio;
    t_pins;
    t_ovf;
    t_irq;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule